// File: doc/BRIEF.md
# ATM Receive Connection Lookup

This block decides, for every received ATM cell, whether the cell belongs to an open connection and, if it does, where that connection's VC table lives. The 8-bit VPI and 16-bit VCI from the cell header are folded into one 16-bit code. A programmable shift moves the low VPI bits into the upper end of the VCI. A programmable mask then trims the code, so that only the bits that actually tell connections apart address the lookup table.

The masked code addresses a table held in a 32-bit control memory. The table starts at word 0, and each word carries two 16-bit entries. An entry holds an enable flag and a VC number. The VC number is the VC table address with its four low zero bits removed. An optional filter discards cells whose bits were lost in the reduction. The filter acts before any memory access is made.

A header is offered with a valid/ready handshake. The block makes one single-cycle read on a synchronous memory port with fixed one-cycle latency. The verdict is held on a result handshake until it is taken. The configuration inputs are sampled only when a header is accepted.

Top module: `atm_rx_lookup`

## Requirements
- R1: The 16-bit code takes VPI bit k at code bit 16-SHIFT+k for every k with 16-SHIFT+k < 16. It takes VCI bit i at code bit i for i < 16-SHIFT. Code bits above the shifted VPI are 0. SHIFT spans 0 to 15.
- R2: The code is ANDed bitwise with the 16-bit mask before any use.
- R3: For a lookup that is not filtered, mem_req_o is high for exactly one cycle, in the cycle after the header is accepted, with mem_addr_o equal to masked code bits 15:1. mem_rdata_i is used in the following cycle, and res_valid_o rises one cycle after that.
- R4: When masked code bit 0 is 0, the entry is mem_rdata_i[31:16]. When it is 1, the entry is mem_rdata_i[15:0].
- R5: Entry bit 15 is the enable flag. With the flag at 1 the result has res_accept_o=1 and res_reason_o=0. With the flag at 0 it has res_accept_o=0 and res_reason_o=2.
- R6: On accept, res_vc_addr_o equals entry bits 14:0 shifted left by 4, zero-extended to 20 bits. On any discard it is 0.
- R7: With cfg_keep_i=0, a header whose dropped bits are not all zero is discarded with res_accept_o=0 and res_reason_o=1. The dropped bits are VPI bits SHIFT and up, and VCI bits 16-SHIFT and up. Such a header issues no memory read, and res_valid_o rises in the cycle after acceptance.
- R8: With cfg_keep_i=1, the dropped bits have no effect, and the lookup proceeds as in R3 to R6.
- R9: SHIFT, mask and cfg_keep_i are sampled when the header is accepted. Changing them afterwards does not alter the result.
- R10: hdr_ready_o is high only when no lookup or result is pending. While res_valid_o is high and res_ready_i is low, the result outputs hold steady.
- R11: After reset, hdr_ready_o=1, res_valid_o=0 and mem_req_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | Header offered |
| hdr_ready_o | output | 1 | Block can take a header |
| hdr_vpi_i | input | 8 | Cell VPI |
| hdr_vci_i | input | 16 | Cell VCI |
| cfg_shift_i | input | 4 | Shift amount that moves the VPI into the VCI |
| cfg_mask_i | input | 16 | Mask applied to the reduced code |
| cfg_keep_i | input | 1 | 1: ignore dropped bits; 0: discard cells with non-zero dropped bits |
| mem_req_o | output | 1 | Control memory read strobe |
| mem_addr_o | output | 15 | Control memory word address |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the strobe |
| res_valid_o | output | 1 | Verdict available |
| res_ready_i | input | 1 | Verdict taken |
| res_accept_o | output | 1 | 1 when the cell is to be received |
| res_reason_o | output | 2 | 0 accepted, 1 filtered, 2 entry disabled |
| res_vc_addr_o | output | 20 | VC table address |

## Verification
The bench builds the block with its default widths: an 8-bit VPI, a 16-bit VCI, a 4-bit shift and a 32-bit memory word. These widths are small enough to sweep every one of the 16 shift values under three masks and both filter settings, with header patterns chosen per shift. Some patterns sit just inside the kept bits, and others set a single dropped bit on the VPI side or the VCI side. Together they reach both filter outcomes at every shift and both halves of the memory word. The memory is modelled as an arithmetic function of the address, so every table entry exists without storage, and enabled and disabled entries alternate in a known pattern.

// File: rtl/atm_rx_pkg.sv
package atm_rx_pkg;

  typedef enum logic [1:0] {
    RSN_NONE     = 2'd0,
    RSN_FILTER   = 2'd1,
    RSN_DISABLED = 2'd2
  } reason_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } lkp_state_e;

endpackage

// File: rtl/atm_code_reduce.sv
module atm_code_reduce #(
  parameter int VPI_W   = 8,
  parameter int VCI_W   = 16,
  parameter int SHIFT_W = 4
) (
  input  logic [VPI_W-1:0]   vpi_i,
  input  logic [VCI_W-1:0]   vci_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [VCI_W-1:0]   code_o,
  output logic               drop_o
);
  localparam int WIDE_W = VPI_W + VCI_W;

  logic [WIDE_W-1:0] wide;
  logic [VCI_W-1:0]  keep;

  // VPI slides down into the VCI field; bits pushed above the code are dropped
  assign wide   = {vpi_i, {VCI_W{1'b0}}} >> shift_i;
  assign keep   = {VCI_W{1'b1}} >> shift_i;
  assign code_o = wide[VCI_W-1:0] | (vci_i & keep);
  assign drop_o = (|wide[WIDE_W-1:VCI_W]) | (|(vci_i & ~keep));

endmodule

// File: rtl/atm_entry_select.sv
module atm_entry_select #(
  parameter int DATA_W   = 32,
  parameter int VCA_W    = 20,
  parameter int VC_SHIFT = 4
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              half_i,
  output logic              en_o,
  output logic [VCA_W-1:0]  vca_o
);
  localparam int ENT_W = DATA_W / 2;
  localparam int VCN_W = ENT_W - 1;
  localparam int PAD_W = VCA_W - VCN_W - VC_SHIFT;

  logic [ENT_W-1:0] entry;

  // half 0 = upper entry, half 1 = lower entry
  assign entry = half_i ? word_i[ENT_W-1:0] : word_i[DATA_W-1:ENT_W];
  assign en_o  = entry[ENT_W-1];

  generate
    if (PAD_W > 0) begin : g_pad
      assign vca_o = {{PAD_W{1'b0}}, entry[VCN_W-1:0], {VC_SHIFT{1'b0}}};
    end else begin : g_nopad
      assign vca_o = {entry[VCN_W-1:0], {VC_SHIFT{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/atm_lookup_ctrl.sv
module atm_lookup_ctrl
  import atm_rx_pkg::*;
#(
  parameter int VCA_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hdr_valid_i,
  output logic             hdr_ready_o,
  input  logic             filt_i,
  output logic             load_o,
  output logic             mem_req_o,
  input  logic             ent_en_i,
  input  logic [VCA_W-1:0] ent_vca_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic             res_accept_o,
  output reason_e          res_reason_o,
  output logic [VCA_W-1:0] res_vca_o
);
  lkp_state_e       state_q;
  logic             acc_q;
  reason_e          rsn_q;
  logic [VCA_W-1:0] vca_q;

  assign hdr_ready_o  = (state_q == ST_IDLE);
  assign load_o       = hdr_valid_i && hdr_ready_o;
  assign mem_req_o    = (state_q == ST_READ);
  assign res_valid_o  = (state_q == ST_DONE);
  assign res_accept_o = acc_q;
  assign res_reason_o = rsn_q;
  assign res_vca_o    = vca_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      acc_q   <= 1'b0;
      rsn_q   <= RSN_NONE;
      vca_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (hdr_valid_i) begin
            if (filt_i) begin
              state_q <= ST_DONE;
              acc_q   <= 1'b0;
              rsn_q   <= RSN_FILTER;
              vca_q   <= '0;
            end else begin
              state_q <= ST_READ;
            end
          end
        end
        ST_READ: state_q <= ST_WAIT;
        ST_WAIT: begin
          state_q <= ST_DONE;
          acc_q   <= ent_en_i;
          rsn_q   <= ent_en_i ? RSN_NONE : RSN_DISABLED;
          vca_q   <= ent_en_i ? ent_vca_i : '0;
        end
        ST_DONE: if (res_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/atm_rx_lookup.sv
module atm_rx_lookup #(
  parameter int VPI_W    = 8,
  parameter int VCI_W    = 16,
  parameter int SHIFT_W  = 4,
  parameter int MEM_DW   = 32,
  parameter int VCA_W    = 20,
  parameter int VC_SHIFT = 4,
  localparam int MEM_AW  = VCI_W - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hdr_valid_i,
  output logic               hdr_ready_o,
  input  logic [VPI_W-1:0]   hdr_vpi_i,
  input  logic [VCI_W-1:0]   hdr_vci_i,
  input  logic [SHIFT_W-1:0] cfg_shift_i,
  input  logic [VCI_W-1:0]   cfg_mask_i,
  input  logic               cfg_keep_i,
  output logic               mem_req_o,
  output logic [MEM_AW-1:0]  mem_addr_o,
  input  logic [MEM_DW-1:0]  mem_rdata_i,
  output logic               res_valid_o,
  input  logic               res_ready_i,
  output logic               res_accept_o,
  output logic [1:0]         res_reason_o,
  output logic [VCA_W-1:0]   res_vc_addr_o
);
  import atm_rx_pkg::*;

  logic [VCI_W-1:0] code_raw;
  logic             drop;
  logic             load;
  logic [VCI_W-1:0] code_q;
  logic             ent_en;
  logic [VCA_W-1:0] ent_vca;
  reason_e          rsn;

  atm_code_reduce #(
    .VPI_W  (VPI_W),
    .VCI_W  (VCI_W),
    .SHIFT_W(SHIFT_W)
  ) u_reduce (
    .vpi_i  (hdr_vpi_i),
    .vci_i  (hdr_vci_i),
    .shift_i(cfg_shift_i),
    .code_o (code_raw),
    .drop_o (drop)
  );

  // masked code captured at accept; config is not looked at again
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_q <= '0;
    else if (load) code_q <= code_raw & cfg_mask_i;
  end

  assign mem_addr_o = code_q[VCI_W-1:1];

  atm_entry_select #(
    .DATA_W  (MEM_DW),
    .VCA_W   (VCA_W),
    .VC_SHIFT(VC_SHIFT)
  ) u_select (
    .word_i(mem_rdata_i),
    .half_i(code_q[0]),
    .en_o  (ent_en),
    .vca_o (ent_vca)
  );

  atm_lookup_ctrl #(
    .VCA_W(VCA_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hdr_valid_i (hdr_valid_i),
    .hdr_ready_o (hdr_ready_o),
    .filt_i      (drop && !cfg_keep_i),
    .load_o      (load),
    .mem_req_o   (mem_req_o),
    .ent_en_i    (ent_en),
    .ent_vca_i   (ent_vca),
    .res_valid_o (res_valid_o),
    .res_ready_i (res_ready_i),
    .res_accept_o(res_accept_o),
    .res_reason_o(rsn),
    .res_vca_o   (res_vc_addr_o)
  );

  assign res_reason_o = rsn;

endmodule

// File: rtl/atm_rx_lookup_chk.sv
module atm_rx_lookup_chk #(
  parameter int VCA_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hdr_ready_o,
  input logic             mem_req_o,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic             res_accept_o,
  input logic [1:0]       res_reason_o,
  input logic [VCA_W-1:0] res_vc_addr_o
);

  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_accept_o)
      && $stable(res_reason_o) && $stable(res_vc_addr_o));

  a_r10_busy_while_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !hdr_ready_o);

  a_r10_busy_while_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !hdr_ready_o);

  a_r3_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r3_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> ##1 res_valid_o);

  a_r5_reason_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_accept_o == (res_reason_o == 2'd0)));

  a_r6_addr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_vc_addr_o[3:0] == 4'd0));

  a_r6_discard_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_accept_o |-> (res_vc_addr_o == '0));

endmodule

bind atm_rx_lookup atm_rx_lookup_chk #(.VCA_W(VCA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hdr_ready_o  (hdr_ready_o),
  .mem_req_o    (mem_req_o),
  .res_valid_o  (res_valid_o),
  .res_ready_i  (res_ready_i),
  .res_accept_o (res_accept_o),
  .res_reason_o (res_reason_o),
  .res_vc_addr_o(res_vc_addr_o)
);

// File: tb/atm_rx_lookup_tb.sv
module atm_rx_lookup_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [7:0]  vpi = '0;
  logic [15:0] vci = '0;
  logic [3:0]  cfg_shift = '0;
  logic [15:0] cfg_mask = '0;
  logic        cfg_keep = 1'b0;
  logic        mem_req;
  logic [14:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_accept;
  logic [1:0]  res_reason;
  logic [19:0] res_vca;

  int n_chk = 0;
  int n_fail = 0;
  int req_cnt = 0;
  logic [14:0] req_addr = '0;
  bit finished = 0;
  logic        l_acc;
  logic [1:0]  l_rsn;
  logic [19:0] l_vca;

  always #(CLK_PERIOD/2) clk = ~clk;

  atm_rx_lookup u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .hdr_valid_i(hdr_valid), .hdr_ready_o(hdr_ready),
    .hdr_vpi_i(vpi), .hdr_vci_i(vci),
    .cfg_shift_i(cfg_shift), .cfg_mask_i(cfg_mask), .cfg_keep_i(cfg_keep),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .res_valid_o(res_valid), .res_ready_i(res_ready),
    .res_accept_o(res_accept), .res_reason_o(res_reason), .res_vc_addr_o(res_vca)
  );

  // table entry for a 16-bit code: enable set unless code is a multiple of 3
  function automatic logic [15:0] ent(input int c);
    logic en;
    en = (c % 3) != 0;
    return {en, 15'((c * 7 + 5) & 32'h7fff)};
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= {ent(2 * int'(mem_addr)), ent(2 * int'(mem_addr) + 1)};
      req_cnt   = req_cnt + 1;
      req_addr  = mem_addr;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_code(input logic [7:0] p, input logic [15:0] c, input int sh);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      if (i >= 16 - sh) r[i] = (i - (16 - sh) < 8) ? p[i - (16 - sh)] : 1'b0;
      else              r[i] = c[i];
    end
    return r;
  endfunction

  task automatic lookup(input logic [7:0] p, input logic [15:0] c, input int sh,
                        input logic [15:0] m, input bit keep, input bit hold);
    logic [15:0] code;
    logic [15:0] e;
    bit          dropped;
    bit          filt;
    int          req0;
    int          waits;
    bit          exp_acc;
    int          exp_rsn;
    int          exp_vca;
    code    = ref_code(p, c, sh) & m;
    dropped = ((int'(p) >> sh) != 0) || (sh != 0 && (int'(c) >> (16 - sh)) != 0);
    filt    = dropped && !keep;
    e       = ent(int'(code));
    exp_acc = !filt && e[15];
    exp_rsn = filt ? 1 : (e[15] ? 0 : 2);
    exp_vca = exp_acc ? int'(e[14:0]) << 4 : 0;

    @(negedge clk);
    hdr_valid = 1'b1; vpi = p; vci = c;
    cfg_shift = 4'(sh); cfg_mask = m; cfg_keep = keep;
    req0 = req_cnt;
    @(posedge clk);
    @(negedge clk);
    hdr_valid = 1'b0;
    // scramble config after accept
    cfg_shift = ~cfg_shift; cfg_mask = ~cfg_mask; cfg_keep = ~cfg_keep;
    vpi = ~vpi; vci = ~vci;
    waits = 0;
    while (!res_valid && waits < 8) begin
      @(negedge clk);
      waits++;
    end
    check(res_valid == 1'b1, "R3", int'(res_valid), 1);
    if (filt) begin
      check(waits == 0, "R7", waits, 0);
      check(req_cnt == req0, "R7", req_cnt - req0, 0);
      check(res_accept == 1'b0 && res_reason == 2'd1, "R7", int'(res_reason), 1);
    end else begin
      check(waits == 2, "R3", waits, 2);
      check(req_cnt == req0 + 1, "R3", req_cnt - req0, 1);
      if (m == 16'hffff) check(req_addr == code[15:1], "R1", int'(req_addr), int'(code[15:1]));
      else               check(req_addr == code[15:1], "R2", int'(req_addr), int'(code[15:1]));
      if (dropped) check(res_reason != 2'd1, "R8", int'(res_reason), exp_rsn);
      check(res_accept == exp_acc, "R5", int'(res_accept), int'(exp_acc));
      check(int'(res_reason) == exp_rsn, "R5", int'(res_reason), exp_rsn);
      if (code[0]) check(int'(res_vca) == exp_vca, "R4", int'(res_vca), exp_vca);
      else         check(int'(res_vca) == exp_vca, "R6", int'(res_vca), exp_vca);
    end
    if (filt) check(res_vca == '0, "R6", int'(res_vca), 0);
    check(hdr_ready == 1'b0, "R10", int'(hdr_ready), 0);
    l_acc = res_accept; l_rsn = res_reason; l_vca = res_vca;
    if (hold) begin
      @(negedge clk);
      check(res_valid && res_accept == l_acc && res_reason == l_rsn && res_vca == l_vca,
            "R10", int'(res_vca), int'(l_vca));
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(!res_valid && hdr_ready, "R10", int'({res_valid, hdr_ready}), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(hdr_ready == 1'b1, "R11", int'(hdr_ready), 1);
    check(res_valid == 1'b0, "R11", int'(res_valid), 0);
    check(mem_req == 1'b0, "R11", int'(mem_req), 0);
    rst_n = 1'b1;

    for (int sh = 0; sh < 16; sh++) begin
      for (int k = 0; k < 2; k++) begin
        for (int mi = 0; mi < 3; mi++) begin
          logic [15:0] m;
          logic [7:0]  pf;
          logic [15:0] cf;
          m  = (mi == 0) ? 16'hffff : (mi == 1) ? 16'hf0f3 : 16'h7ffe;
          pf = (sh < 8) ? (8'hb7 & 8'((1 << sh) - 1)) : 8'hb7;
          cf = 16'ha5c3 >> sh;
          for (int p = 0; p < 6; p++) begin
            logic [7:0]  pv;
            logic [15:0] cv;
            case (p)
              0: begin pv = pf; cv = cf; end
              1: begin pv = 8'h00; cv = 16'hffff >> sh; end
              2: begin pv = (sh < 8) ? (pf | 8'(1 << sh)) : pf; cv = cf; end
              3: begin pv = pf; cv = cf | 16'h8000; end
              4: begin pv = 8'hff; cv = 16'hffff; end
              default: begin pv = 8'((sh * 29 + 3) & 255); cv = 16'((sh * 4099 + mi * 77 + 1) & 16'hffff); end
            endcase
            lookup(pv, cv, sh, m, k[0], p == 5);
          end
        end
      end
    end

    // R9: result follows the config seen at accept, not the scrambled one
    lookup(8'h12, 16'h0034, 8, 16'hffff, 1'b0, 1'b1);
    check(l_acc == ent(16'h1234) >> 15, "R9", int'(l_acc), int'(ent(16'h1234) >> 15));
    check(l_vca == 20'(ent(16'h1234) & 16'h7fff) << 4, "R9", int'(l_vca),
          int'(ent(16'h1234) & 16'h7fff) << 4);
    lookup(8'h00, 16'h0005, 3, 16'hffff, 1'b0, 1'b0);
    check(l_rsn == 2'd0 && l_vca == 20'(ent(5) & 16'h7fff) << 4, "R9", int'(l_vca),
          int'(ent(5) & 16'h7fff) << 4);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule